// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the configuration state of an interrupt routing controller and makes it reachable from a processor bus through just two 32-bit locations: a select register and a data window. Software first writes a register index into the select location, then reads or writes the window to reach the register that index names. Behind the window are a 4-bit identification register, a read-only version word, a 4-bit arbitration identifier and a table of 64-bit routing entries, one per interrupt input. Each entry takes two consecutive index values, the even one for its low half and the odd one for its high half.

The decoded table is driven out in parallel so that the dispatch logic can read every entry at once. Each bus request is a single-cycle pulse of `bus_valid`, with `bus_write`, `bus_addr` and `bus_wdata`. Exactly one cycle later the block returns a response pulse with read data, an address-error flag and an undefined-index warning flag. Every request gets a response, including illegal ones.

Top module: `irq_route_regs`

## Requirements
- R1: Only byte offsets 0 (select) and 16 (window) are legal. Any other offset gives a response with `rsp_addr_err`=1, `rsp_undef_warn`=0 and read data 0, and changes no state.
- R2: Every request with `bus_valid`=1 gets `rsp_valid`=1 in the next cycle. No request means `rsp_valid`=0 in the next cycle. Writes return read data 0.
- R3: A write to offset 0 stores `bus_wdata[7:0]` as the index. A read of offset 0 returns the index zero-extended to 32 bits. The index resets to 0.
- R4: Window index 0 is the ID. A write stores `bus_wdata[27:24]`. A read returns the ID in bits 27:24, with all other bits zero. Its reset value is the parameter `ID_RESET`.
- R5: Window index 1 is read-only and returns {8'h00, NUM_ENT-1, 8'h00, VERSION}. Writes to it change nothing.
- R6: Window index 2 is the arbitration ID. It uses the same bit 27:24 layout as the ID, resets to `ID_RESET`, and is independent of writes to the ID.
- R7: Window index 0x10+2n reaches bits 31:0 of entry n, and index 0x10+2n+1 reaches bits 63:32. Entry n appears on `route_o[64n+63:64n]`.
- R8: At reset every entry equals 64'h0000_0000_0001_0000, which means only the mask bit (bit 16) is set.
- R9: A write to the low half keeps only the bits in mask 32'h0001_AFFF: vector 7:0, mode 10:8, destination mode 11, polarity 13, trigger 15 and mask 16. A write to the high half keeps only the bits in 32'hFF00_0000, the destination. All other bits of the half are stored as zero.
- R10: Undefined window indices are 3 to 0x0F and 0x10+2*NUM_ENT and above. A read of one returns 0 with `rsp_undef_warn`=1. A write to one also raises the warning and changes nothing.
- R11: A written entry shows the new value on `route_o` in the cycle after the write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_addr_err | output | 1 | Illegal byte offset |
| rsp_undef_warn | output | 1 | Window access to an undefined index |
| route_o | output | 64*NUM_ENT | All routing entries, entry n in bits 64n+63:64n |

## Verification
The bench targets the edges of the index space.
- It probes index 2 against index 3, index 0x0F against 0x10, and the last entry's high half against the first index past the table. A decoder with an off-by-one at the table's end would accept a write beyond the last entry or reject a write to the last entry.
- It writes all-ones to both halves of entries. A design that does not clear reserved bits would show them on `route_o`.
- It writes to the version word and to illegal offsets, then reads the version word back and compares the whole table. A design with a stray write enable would change state there.
- Random traffic mixes select writes, window accesses and illegal offsets against a bench model. This catches halves that are swapped, an ID and arbitration ID that alias, and responses that arrive late.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Kinds of access after offset and index decode
    typedef enum logic [2:0] {
        K_SEL,
        K_ID,
        K_VER,
        K_ARB,
        K_ENTRY,
        K_UNDEF,
        K_BADADDR
    } acc_kind_e;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } route_ent_t;

    localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
    localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
    localparam logic [31:0] LO_RESET = 32'h0001_0000;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_ENT = 24,
    parameter int unsigned ENT_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        sel,
    output acc_kind_e         kind,
    output logic [ENT_W-1:0]  ent_idx,
    output logic              ent_hi
);
    localparam int unsigned SEL_OFF   = 0;
    localparam int unsigned WIN_OFF   = 16;
    localparam int unsigned TBL_BASE  = 16;
    localparam int unsigned TBL_LIMIT = TBL_BASE + 2 * NUM_ENT;

    logic [7:0] rel;

    always_comb begin
        rel     = sel - 8'(TBL_BASE);
        ent_idx = ENT_W'(rel[7:1]);
        ent_hi  = sel[0];
        if (int'(addr) == SEL_OFF) begin
            kind = K_SEL;
        end else if (int'(addr) != WIN_OFF) begin
            kind = K_BADADDR;
        end else if (sel == 8'd0) begin
            kind = K_ID;
        end else if (sel == 8'd1) begin
            kind = K_VER;
        end else if (sel == 8'd2) begin
            kind = K_ARB;
        end else if (int'(sel) >= TBL_BASE && int'(sel) < TBL_LIMIT) begin
            kind = K_ENTRY;
        end else begin
            kind = K_UNDEF;
        end
    end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_ENT = 24,
    parameter int unsigned ENT_W   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ENT_W-1:0]       wr_idx,
    input  logic                   wr_hi,
    input  logic [31:0]            wr_data,
    input  logic [ENT_W-1:0]       rd_idx,
    input  logic                   rd_hi,
    output logic [31:0]            rd_data,
    output logic [64*NUM_ENT-1:0]  route_o
);
    route_ent_t tbl_d [NUM_ENT];
    route_ent_t tbl_q [NUM_ENT];

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_en && int'(wr_idx) < NUM_ENT) begin
            if (wr_hi) begin
                tbl_d[wr_idx].hi = wr_data & HI_KEEP;
            end else begin
                tbl_d[wr_idx].lo = wr_data & LO_KEEP;
            end
        end
        rd_data = '0;
        if (int'(rd_idx) < NUM_ENT) begin
            rd_data = rd_hi ? tbl_q[rd_idx].hi : tbl_q[rd_idx].lo;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!rst_n) begin
                tbl_q[i] <= '{hi: 32'h0, lo: LO_RESET};
            end else begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign route_o[64*g +: 64] = tbl_q[g];

        // R9: reserved bits never reach the stored entry
        p_resv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((tbl_q[g].lo & ~LO_KEEP) == 32'h0) && ((tbl_q[g].hi & ~HI_KEEP) == 32'h0));

        // R11: a low-half write to this entry lands one cycle later
        p_lo_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_hi && int'(wr_idx) == g) |=>
                (tbl_q[g].lo == ($past(wr_data) & LO_KEEP)));
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_ENT  = 24,
    parameter logic [3:0]  ID_RESET = 4'h0,
    parameter logic [7:0]  VERSION  = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_rdata,
    output logic                   rsp_addr_err,
    output logic                   rsp_undef_warn,
    output logic [64*NUM_ENT-1:0]  route_o
);
    localparam int unsigned ENT_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VERSION};

    typedef struct packed {
        logic [7:0]  sel;
        logic [3:0]  id;
        logic [3:0]  arb;
        logic        rsp_valid;
        logic [31:0] rdata;
        logic        err;
        logic        warn;
    } regs_t;

    regs_t            st_d, st_q;
    acc_kind_e        kind;
    logic [ENT_W-1:0] ent_idx;
    logic             ent_hi;
    logic             tbl_wr;
    logic [31:0]      tbl_rd;

    irq_route_decode #(
        .ADDR_W (ADDR_W),
        .NUM_ENT(NUM_ENT),
        .ENT_W  (ENT_W)
    ) u_dec (
        .addr   (bus_addr),
        .sel    (st_q.sel),
        .kind   (kind),
        .ent_idx(ent_idx),
        .ent_hi (ent_hi)
    );

    irq_route_table #(
        .NUM_ENT(NUM_ENT),
        .ENT_W  (ENT_W)
    ) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr),
        .wr_idx (ent_idx),
        .wr_hi  (ent_hi),
        .wr_data(bus_wdata),
        .rd_idx (ent_idx),
        .rd_hi  (ent_hi),
        .rd_data(tbl_rd),
        .route_o(route_o)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = bus_valid;
        st_d.rdata     = '0;
        st_d.err       = 1'b0;
        st_d.warn      = 1'b0;
        tbl_wr         = 1'b0;
        if (bus_valid) begin
            case (kind)
                K_SEL: begin
                    if (bus_write) st_d.sel = bus_wdata[7:0];
                    else           st_d.rdata = {24'h0, st_q.sel};
                end
                K_ID: begin
                    if (bus_write) st_d.id = bus_wdata[27:24];
                    else           st_d.rdata = {4'h0, st_q.id, 24'h0};
                end
                K_VER: begin
                    if (!bus_write) st_d.rdata = VER_WORD;
                end
                K_ARB: begin
                    if (bus_write) st_d.arb = bus_wdata[27:24];
                    else           st_d.rdata = {4'h0, st_q.arb, 24'h0};
                end
                K_ENTRY: begin
                    if (bus_write) tbl_wr = 1'b1;
                    else           st_d.rdata = tbl_rd;
                end
                K_UNDEF: st_d.warn = 1'b1;
                default: st_d.err  = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.id  <= ID_RESET;
            st_q.arb <= ID_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid      = st_q.rsp_valid;
    assign rsp_rdata      = st_q.rdata;
    assign rsp_addr_err   = st_q.err;
    assign rsp_undef_warn = st_q.warn;

    // R2: every request is answered in the next cycle
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> rsp_valid);
    // R2: no request, no response
    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !rsp_valid);
    // R1: an illegal offset returns zero data and no warning
    p_bad_addr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_err |-> (rsp_rdata == 32'h0 && !rsp_undef_warn && rsp_valid));
    // R1: an illegal-offset write leaves the table unchanged
    p_bad_addr_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && kind == K_BADADDR) |=> $stable(route_o));
    // R10: an undefined index reads as zero
    p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef_warn |-> (rsp_rdata == 32'h0 && rsp_valid));
endmodule

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned NUM_ENT = 24;
    localparam logic [3:0]  ID_RST  = 4'h5;
    localparam logic [7:0]  VER     = 8'h20;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_valid = 1'b0;
    logic                  bus_write = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic                  rsp_valid;
    logic [31:0]           rsp_rdata;
    logic                  rsp_addr_err;
    logic                  rsp_undef_warn;
    logic [64*NUM_ENT-1:0] route_o;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    // Bench model
    logic [7:0]  m_sel;
    logic [3:0]  m_id, m_arb;
    logic [31:0] m_lo [NUM_ENT];
    logic [31:0] m_hi [NUM_ENT];

    always #4 clk = ~clk;

    irq_route_regs #(
        .ADDR_W  (ADDR_W),
        .NUM_ENT (NUM_ENT),
        .ID_RESET(ID_RST),
        .VERSION (VER)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_addr_err(rsp_addr_err),
        .rsp_undef_warn(rsp_undef_warn), .route_o(route_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_undef(input logic [7:0] s);
        return (s >= 8'd3 && s < 8'h10) || (int'(s) >= 16 + 2 * NUM_ENT);
    endfunction

    function automatic logic [31:0] exp_window(input logic [7:0] s);
        if (s == 8'd0) return {4'h0, m_id, 24'h0};
        if (s == 8'd1) return {8'h00, 8'(NUM_ENT - 1), 8'h00, VER};
        if (s == 8'd2) return {4'h0, m_arb, 24'h0};
        if (is_undef(s)) return 32'h0;
        return s[0] ? m_hi[(s - 8'h10) >> 1] : m_lo[(s - 8'h10) >> 1];
    endfunction

    function automatic string tag_of(input logic [7:0] a, input logic [7:0] s);
        if (a != 8'd0 && a != 8'd16) return "R1";
        if (a == 8'd0) return "R3";
        if (s == 8'd0) return "R4";
        if (s == 8'd1) return "R5";
        if (s == 8'd2) return "R6";
        if (is_undef(s)) return "R10";
        return "R7";
    endfunction

    task automatic model_reset();
        m_sel = 8'h0; m_id = ID_RST; m_arb = ID_RST;
        for (int i = 0; i < NUM_ENT; i++) begin
            m_lo[i] = 32'h0001_0000;
            m_hi[i] = 32'h0;
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] e_data;
        bit          e_err, e_warn;
        string       tag;
        tag    = tag_of(a, m_sel);
        e_err  = (a != 8'd0 && a != 8'd16);
        e_warn = (a == 8'd16) && is_undef(m_sel);
        if (wr || e_err) e_data = 32'h0;
        else if (a == 8'd0) e_data = {24'h0, m_sel};
        else e_data = exp_window(m_sel);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        check(rsp_valid == 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
        check(rsp_addr_err == e_err, {tag, " addr_err"}, 64'(rsp_addr_err), 64'(e_err));
        check(rsp_undef_warn == e_warn, {tag, " undef_warn"}, 64'(rsp_undef_warn), 64'(e_warn));
        check(rsp_rdata == e_data, {tag, " rdata"}, 64'(rsp_rdata), 64'(e_data));
        if (wr && !e_err) begin
            if (a == 8'd0) m_sel = d[7:0];
            else if (m_sel == 8'd0) m_id = d[27:24];
            else if (m_sel == 8'd2) m_arb = d[27:24];
            else if (m_sel >= 8'h10 && !is_undef(m_sel)) begin
                if (m_sel[0]) m_hi[(m_sel - 8'h10) >> 1] = d & 32'hFF00_0000;
                else          m_lo[(m_sel - 8'h10) >> 1] = d & 32'h0001_AFFF;
            end
        end
    endtask

    // R7 / R11: whole-table compare on the parallel outputs
    task automatic check_routes(input string tag);
        for (int i = 0; i < NUM_ENT; i++) begin
            check(route_o[64*i +: 64] == {m_hi[i], m_lo[i]}, tag,
                  route_o[64*i +: 64], {m_hi[i], m_lo[i]});
        end
    endtask

    task automatic win_wr(input logic [7:0] s, input logic [31:0] d);
        access(1'b1, 8'd0, {24'h0, s});
        access(1'b1, 8'd16, d);
    endtask

    task automatic win_rd(input logic [7:0] s);
        access(1'b1, 8'd0, {24'h0, s});
        access(1'b0, 8'd16, 32'h0);
    endtask

    initial begin
        logic [7:0] a, s;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(rsp_valid == 1'b0, "R2 idle after reset", 64'(rsp_valid), 64'd0);
        check_routes("R8 reset entries");
        access(1'b0, 8'd0, 32'h0);           // R3 reset index
        win_rd(8'd0);                        // R4 reset ID
        win_rd(8'd2);                        // R6 arb resets to ID
        win_rd(8'd1);                        // R5 version
        // R5: write ignored
        win_wr(8'd1, 32'hFFFF_FFFF);
        access(1'b0, 8'd16, 32'h0);
        // R6: ID and arb independent
        win_wr(8'd0, 32'h0A00_0000);
        win_rd(8'd2);
        win_wr(8'd2, 32'hF3FF_FFFF);
        win_rd(8'd0);
        win_rd(8'd2);
        // R9: reserved bits cleared, R11 visible next cycle
        win_wr(8'h10, 32'hFFFF_FFFF);
        win_wr(8'h11, 32'hFFFF_FFFF);
        check_routes("R11 entry 0 after write");
        win_rd(8'h10);
        win_rd(8'h11);
        // R7 boundaries: last entry halves, then first index past table
        win_wr(8'(16 + 2 * NUM_ENT - 1), 32'hABCD_EF01);
        win_wr(8'(16 + 2 * NUM_ENT - 2), 32'h1234_5678);
        win_wr(8'(16 + 2 * NUM_ENT), 32'hFFFF_FFFF);
        win_rd(8'(16 + 2 * NUM_ENT));
        win_wr(8'd3, 32'hFFFF_FFFF);
        win_wr(8'h0F, 32'hFFFF_FFFF);
        win_rd(8'h0F);
        check_routes("R10 undefined writes have no effect");
        // R1: illegal offsets
        access(1'b1, 8'd4, 32'hFFFF_FFFF);
        access(1'b1, 8'd17, 32'hFFFF_FFFF);
        access(1'b0, 8'd32, 32'h0);
        access(1'b0, 8'd0, 32'h0);
        check_routes("R1 illegal writes have no effect");
        // R2: no request, no response
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 idle gap", 64'(rsp_valid), 64'd0);
        // Random traffic
        void'($urandom(32'h1234_5678));
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            if (r < 3) begin
                s = 8'($urandom_range(0, 16 + 2 * NUM_ENT + 4));
                access(1'b1, 8'd0, {$urandom, s} >> 0 & 32'hFFFF_FF00 | {24'h0, s});
            end else if (r < 9) begin
                access(r[0], 8'd16, $urandom);
            end else begin
                a = 8'($urandom_range(1, 255));
                if (a == 8'd16) a = 8'd20;
                access($urandom_range(0, 1) == 1, a, $urandom);
            end
            if (k % 100 == 0) check_routes("R7 random table compare");
        end
        check_routes("R11 final table compare");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired (R2) actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule